// File: doc/BRIEF.md
# Phase-Offset Clock Divider Bank

This block turns one reference clock into four divided square waves. Each channel has its own integer divide ratio and its own start offset. The offset is a whole number of enabled reference cycles, counted from the first rising edge of channel 0. Channel 0 is the alignment reference and is never offset. Everything runs synchronously on the reference clock. A clock enable gates progress. The outputs are registered levels intended to drive logic, not gated clocks.

Ratios and offsets arrive on configuration inputs but take effect only on a restart strobe. The restart captures the ratios, loads every offset counter and clears every phase counter on the same edge. As a result, the phase relation between channels is identical after every restart. A ratio below two cannot make a square wave, so it is replaced by two and flagged on a per-channel error bit. At a 50 MHz reference one offset step is 20 ns. No finer offset is possible in this scheme.

Top module: `phase_div_bank`

## Requirements
- R1: After synchronous reset every `clk_div` and `ratio_err` bit is 0, and they stay 0 until the first restart, whatever the configuration inputs and `ce` do.
- R2: On the clock edge where `restart` is 1 (independent of `ce`), all outputs go low, all phase counters clear and the new ratios and offsets are captured.
- R3: Channel 0 (bit 0) rises on the first enabled edge after the restart edge. Its offset field `cfg_delay[7:0]` is ignored.
- R4: For channel k of 1 to 3, the first rising edge of `clk_div[k]` comes exactly D_k enabled cycles after the first rising edge of `clk_div[0]`. D_k is `cfg_delay[8k+7:8k]`, an unsigned value from 0 to 255.
- R5: Once started, channel k repeats with a period of exactly N_k enabled cycles. N_k is `cfg_ratio[8k+7:8k]`, an unsigned value from 2 to 255, and the waveform never drifts.
- R6: For an even N, the output is high for N/2 enabled cycles per period, starting at its rising edge.
- R7: For an odd N, the output is high for (N+1)/2 enabled cycles and low for (N-1)/2 enabled cycles.
- R8: A ratio field of 0 or 1 at restart runs that channel at ratio 2 and sets `ratio_err[k]`. A later restart with a legal ratio clears that bit. The bit changes only at a restart.
- R9: While `ce` is 0 (and no restart), no output, offset counter or phase counter changes.
- R10: Changing `cfg_ratio` or `cfg_delay` without a restart has no effect on the running waveforms.
- R11: A restart while channels are running re-aligns them exactly as a restart from idle does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| ce | input | 1 | Clock enable; each enabled edge is one offset/divide step |
| restart | input | 1 | Capture configuration and re-align all channels |
| cfg_ratio | input | 32 | Four 8-bit divide ratios, channel k in bits [8k+7:8k] |
| cfg_delay | input | 32 | Four 8-bit offsets in enabled cycles, channel k in bits [8k+7:8k] |
| clk_div | output | 4 | Divided outputs, bit k is channel k |
| ratio_err | output | 4 | Bit k set when channel k was given a ratio below 2 |

## Verification
Each output is one register away from the counters. The restart effect is therefore visible right after the restart edge, and channel 0's first high level appears after the next enabled edge. A channel with offset D rises D enabled edges after that. The bench samples on the falling edge and keeps its own count of enabled edges since the restart. From that count it predicts every output bit arithmetically, as ((e-1-D) mod N) < (N+1)/2 or low before the offset expires. It compares this prediction on every cycle and also measures first-rise spacing, period and high time from the observed edges. Error bits are compared on the first sample after each restart.

// File: rtl/phd_pkg.sv
package phd_pkg;

    // Smallest ratio that still yields a square wave.
    localparam int MIN_RATIO = 2;

    // Offset counter progress after a restart.
    typedef enum logic [1:0] {
        DLY_IDLE = 2'd0,
        DLY_WAIT = 2'd1,
        DLY_DONE = 2'd2
    } dly_state_e;

    // Divider run flags.
    typedef struct packed {
        logic run;
        logic lvl;
    } div_flags_t;

    // High time in enabled cycles for a ratio n (even: n/2, odd: (n+1)/2).
    function automatic int unsigned high_len(input int unsigned n);
        return (n + 1) / 2;
    endfunction

endpackage

// File: rtl/phd_cfg_latch.sv
module phd_cfg_latch #(
    parameter int RATIO_W = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               restart,
    input  logic [RATIO_W-1:0] ratio_in,
    output logic [RATIO_W-1:0] ratio_q,
    output logic               err_q
);
    import phd_pkg::*;

    localparam logic [RATIO_W-1:0] FLOOR = RATIO_W'(MIN_RATIO);

    logic bad;
    assign bad = (ratio_in < FLOOR);

    always_ff @(posedge clk) begin
        if (rst) begin
            ratio_q <= FLOOR;
            err_q   <= 1'b0;
        end else if (restart) begin
            ratio_q <= bad ? FLOOR : ratio_in;
            err_q   <= bad;
        end
    end

    AST_RATIO_FLOOR: assert property (@(posedge clk) disable iff (rst)
        ratio_q >= FLOOR);  // R8

endmodule

// File: rtl/phd_delay_unit.sv
module phd_delay_unit #(
    parameter int DELAY_W = 8,
    parameter bit BYPASS  = 1'b0
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               ce,
    input  logic               restart,
    input  logic [DELAY_W-1:0] dly_in,
    output logic               start
);
    import phd_pkg::*;

    dly_state_e         state;
    logic [DELAY_W-1:0] cnt;
    logic [DELAY_W-1:0] load_val;

    assign load_val = BYPASS ? '0 : dly_in;
    assign start    = ce && !restart && (state == DLY_WAIT) && (cnt == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= DLY_IDLE;
            cnt   <= '0;
        end else if (restart) begin
            state <= DLY_WAIT;
            cnt   <= load_val;
        end else if (ce && state == DLY_WAIT) begin
            if (cnt == '0) state <= DLY_DONE;
            else           cnt   <= cnt - 1'b1;
        end
    end

    AST_DLY_STEP: assert property (@(posedge clk) disable iff (rst)
        (state == DLY_WAIT && ce && !restart && cnt != '0) |=> cnt == $past(cnt) - 1'b1);  // R4
    AST_DLY_SINGLE_START: assert property (@(posedge clk) disable iff (rst)
        start |=> !start);  // R4
    AST_DLY_FREEZE: assert property (@(posedge clk) disable iff (rst)
        (!ce && !restart) |=> ($stable(cnt) && $stable(state)));  // R9

endmodule

// File: rtl/phd_divider.sv
module phd_divider #(
    parameter int RATIO_W = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               ce,
    input  logic               restart,
    input  logic               start,
    input  logic [RATIO_W-1:0] ratio,
    output logic               clk_out
);
    import phd_pkg::*;

    div_flags_t         fl;
    logic [RATIO_W-1:0] ph;
    logic [RATIO_W:0]   hi;
    logic               wrap;

    assign hi      = ({1'b0, ratio} + 1'b1) >> 1;
    assign wrap    = (ph == ratio - 1'b1);
    assign clk_out = fl.lvl;

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            fl <= '{run: 1'b0, lvl: 1'b0};
            ph <= '0;
        end else if (start) begin
            fl <= '{run: 1'b1, lvl: 1'b1};
            ph <= RATIO_W'(1);
        end else if (ce && fl.run) begin
            fl.lvl <= ({1'b0, ph} < hi);
            ph     <= wrap ? '0 : ph + 1'b1;
        end
    end

    AST_PH_RANGE: assert property (@(posedge clk) disable iff (rst)
        fl.run |-> (ph < ratio));  // R5
    AST_RISE_ALIGN: assert property (@(posedge clk) disable iff (rst)
        $rose(clk_out) |-> (ph == RATIO_W'(1)));  // R5
    AST_RESTART_LOW: assert property (@(posedge clk) disable iff (rst)
        restart |=> !clk_out);  // R2
    AST_FREEZE: assert property (@(posedge clk) disable iff (rst)
        (!ce && !restart) |=> ($stable(clk_out) && $stable(ph)));  // R9

endmodule

// File: rtl/phase_div_bank.sv
module phase_div_bank #(
    parameter int NUM_OUT = 4,
    parameter int RATIO_W = 8,
    parameter int DELAY_W = 8
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       ce,
    input  logic                       restart,
    input  logic [NUM_OUT*RATIO_W-1:0] cfg_ratio,
    input  logic [NUM_OUT*DELAY_W-1:0] cfg_delay,
    output logic [NUM_OUT-1:0]         clk_div,
    output logic [NUM_OUT-1:0]         ratio_err
);
    import phd_pkg::*;

    logic [NUM_OUT-1:0] start_v;
    logic [NUM_OUT-1:0] ratio_bad;

    for (genvar i = 0; i < NUM_OUT; i++) begin : g_ch
        logic [RATIO_W-1:0] ratio_q;

        assign ratio_bad[i] = (cfg_ratio[i*RATIO_W +: RATIO_W] < RATIO_W'(MIN_RATIO));

        phd_cfg_latch #(.RATIO_W(RATIO_W)) u_cfg (
            .clk      (clk),
            .rst      (rst),
            .restart  (restart),
            .ratio_in (cfg_ratio[i*RATIO_W +: RATIO_W]),
            .ratio_q  (ratio_q),
            .err_q    (ratio_err[i])
        );

        // Channel 0 is the alignment reference and never waits.
        phd_delay_unit #(.DELAY_W(DELAY_W), .BYPASS(i == 0)) u_dly (
            .clk     (clk),
            .rst     (rst),
            .ce      (ce),
            .restart (restart),
            .dly_in  (cfg_delay[i*DELAY_W +: DELAY_W]),
            .start   (start_v[i])
        );

        phd_divider #(.RATIO_W(RATIO_W)) u_div (
            .clk     (clk),
            .rst     (rst),
            .ce      (ce),
            .restart (restart),
            .start   (start_v[i]),
            .ratio   (ratio_q),
            .clk_out (clk_div[i])
        );
    end

    AST_ERR_CAPTURE: assert property (@(posedge clk) disable iff (rst)
        restart |=> (ratio_err == $past(ratio_bad)));  // R8
    AST_ERR_HOLD: assert property (@(posedge clk) disable iff (rst)
        !restart |=> $stable(ratio_err));  // R8
    AST_REF_FIRST: assert property (@(posedge clk) disable iff (rst)
        (start_v != '0) |-> (start_v[0] || !$past(restart)));  // R3

endmodule

// File: tb/sim_phase_div_bank.sv
module sim_phase_div_bank;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ce = 1'b0;
    logic        restart = 1'b0;
    logic [31:0] cfg_ratio = '0;
    logic [31:0] cfg_delay = '0;
    logic [3:0]  clk_div;
    logic [3:0]  ratio_err;

    int n_chk  = 0;
    int n_fail = 0;
    bit ran_before = 1'b0;

    always #10ns clk = ~clk;

    phase_div_bank u0 (
        .clk       (clk),
        .rst       (rst),
        .ce        (ce),
        .restart   (restart),
        .cfg_ratio (cfg_ratio),
        .cfg_delay (cfg_delay),
        .clk_div   (clk_div),
        .ratio_err (ratio_err)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic run_cfg(input int r[4], input int d[4], input bit gaps, input bit scramble);
        int e[4], dv[4], rise1[4], rise2[4], highc[4], mism[4], prev[4];
        int max_d, max_e, need, win, en, exp_err;
        string wreq;
        max_d = 0; max_e = 0; exp_err = 0;
        for (int k = 0; k < 4; k++) begin
            e[k]  = (r[k] < 2) ? 2 : r[k];
            dv[k] = (k == 0) ? 0 : d[k];
            if (r[k] < 2) exp_err |= (1 << k);
            if (dv[k] > max_d) max_d = dv[k];
            if (e[k] > max_e) max_e = e[k];
            rise1[k] = -1; rise2[k] = -1; highc[k] = 0; mism[k] = 0; prev[k] = 0;
        end
        need = max_d + 2 * max_e + 4;
        win  = gaps ? (need * 3) / 2 + 3 : need;
        wreq = gaps ? "R9" : (scramble ? "R10" : "R5");

        @(negedge clk);
        for (int k = 0; k < 4; k++) begin
            cfg_ratio[k*8 +: 8] = 8'(r[k]);
            cfg_delay[k*8 +: 8] = 8'(d[k]);
        end
        restart = 1'b1;
        ce      = 1'b1;
        @(negedge clk);
        restart = 1'b0;
        chk(clk_div == 4'b0, "R2", "outputs low after restart", int'(clk_div), 0);
        chk(int'(ratio_err) == exp_err, "R8", "error bits after restart", int'(ratio_err), exp_err);

        en = 0;
        for (int n = 1; n <= win; n++) begin
            bit this_ce;
            this_ce = gaps ? ((n % 3) != 0) : 1'b1;
            ce = this_ce;
            if (scramble && n == win / 2) begin
                cfg_ratio = cfg_ratio ^ 32'h5A3C_0F81;
                cfg_delay = cfg_delay ^ 32'h1F2E_3D4C;
            end
            @(posedge clk);
            if (this_ce) en++;
            @(negedge clk);
            for (int k = 0; k < 4; k++) begin
                int t, ev, v;
                t  = en - 1 - dv[k];
                ev = (t < 0) ? 0 : (((t % e[k]) < (e[k] + 1) / 2) ? 1 : 0);
                v  = int'(clk_div[k]);
                if (v != ev) mism[k]++;
                if (v == 1 && prev[k] == 0) begin
                    if (rise1[k] < 0) rise1[k] = en;
                    else if (rise2[k] < 0) rise2[k] = en;
                end
                if (rise1[k] >= 0 && rise2[k] < 0 && this_ce && v == 1) highc[k]++;
                prev[k] = v;
            end
        end
        ce = 1'b1;

        for (int k = 0; k < 4; k++) begin
            chk(mism[k] == 0, wreq, $sformatf("ch%0d waveform mismatches", k), mism[k], 0);
            if (k == 0) begin
                chk(rise1[0] == 1, "R3", "ch0 first rise enabled edge", rise1[0], 1);
                if (ran_before)
                    chk(rise1[0] == 1, "R11", "re-align after running restart", rise1[0], 1);
            end else begin
                chk(rise1[k] - rise1[0] == dv[k], "R4", $sformatf("ch%0d offset", k),
                    rise1[k] - rise1[0], dv[k]);
            end
            chk(rise2[k] - rise1[k] == e[k], "R5", $sformatf("ch%0d period", k),
                rise2[k] - rise1[k], e[k]);
            chk(highc[k] == (e[k] + 1) / 2, (e[k] % 2) ? "R7" : "R6",
                $sformatf("ch%0d high time", k), highc[k], (e[k] + 1) / 2);
        end
        ran_before = 1'b1;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        int low_errs;
        cfg_ratio = 32'h0001_0000;
        cfg_delay = 32'h0302_0100;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: idle after reset, no restart given
        low_errs = 0;
        for (int n = 0; n < 12; n++) begin
            ce = (n % 2 == 0);
            cfg_ratio = cfg_ratio + 32'h0103_0507;
            @(negedge clk);
            if (clk_div != 4'b0 || ratio_err != 4'b0) low_errs++;
        end
        chk(low_errs == 0, "R1", "idle outputs nonzero samples", low_errs, 0);
        chk(clk_div == 4'b0, "R1", "clk_div after reset", int'(clk_div), 0);
        chk(ratio_err == 4'b0, "R1", "ratio_err after reset", int'(ratio_err), 0);

        run_cfg('{2, 4, 10, 5},   '{9, 1, 3, 0},      1'b0, 1'b0);
        run_cfg('{16, 24, 64, 2}, '{0, 7, 19, 4},     1'b0, 1'b0);
        run_cfg('{0, 1, 3, 7},    '{0, 0, 255, 1},    1'b0, 1'b0);
        run_cfg('{5, 6, 9, 2},    '{0, 2, 5, 11},     1'b1, 1'b0);
        run_cfg('{4, 3, 8, 12},   '{3, 6, 2, 1},      1'b0, 1'b1);
        run_cfg('{255, 254, 2, 128}, '{0, 255, 0, 128}, 1'b0, 1'b0);
        for (int n = 2; n <= 33; n++)
            run_cfg('{n, n + 1, 2 * n, 3}, '{n, n, 2 * n, 255 - n}, (n % 5) == 0, 1'b0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule